// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous Byte Memory

This block is a single-port synchronous byte memory that never needs an idle cycle when the bus changes direction. Each operation is split in two: a command cycle, in which address and controls are captured on a rising clock edge, and a data cycle one clock later. A read places its byte on the output during that data cycle straight from the array, with no extra output register. A write takes its byte from the data input at the clock edge that closes the data cycle. Because every operation has the same one-cycle offset, reads and writes can follow each other in any order on consecutive cycles.

Captured write bytes sit in a one-entry commit buffer until the next active edge moves them into the array. A read that lands on the buffered address is served from the buffer. A clock-enable input freezes the whole pipeline. A chip-select input stops new commands but lets the one in flight finish. An output-enable input idles the read port at once, without waiting for the clock. All controls are active low. The address port is 17 bits wide. The array decodes the low `STORE_AW` bits, so its depth can be sized per instance.

Top module: `zbt_flow_sram`

## Requirements
- R1: After reset no operation is pending, `qValid` is 0 and `qOut` is 0 until a read is launched.
- R2: A read launched at edge k (`cenN`=0, `csN`=0, `weN`=1) shows the stored byte on `qOut` with `qValid`=1 after edge k, combinationally from the array, until the next active edge.
- R3: A write launched at edge k (`weN`=0) stores the byte on `dIn` at the next edge where `cenN`=0, at the address captured at edge k. Later reads of that address return it.
- R4: A read of an address whose write is still in the commit buffer returns the buffered byte, so a read right after a write to the same address gets the new data.
- R5: Reads and writes may alternate on every cycle with no idle cycle, and each one keeps its one-cycle command-to-data offset.
- R6: While `cenN`=1, the `csN`, `weN`, `addr` and `dIn` inputs are ignored. All pipeline state holds, so a read in its data cycle keeps driving the same byte, and a pending write waits for the next enabled edge to take its data.
- R7: An enabled edge with `csN`=1 launches nothing, so the following cycle has `qValid`=0. A write launched on the edge before still completes with the data present at that edge.
- R8: `oeN`=1 forces `qValid`=0 and `qOut`=0 immediately, with no clock edge needed. Returning `oeN` to 0 restores the read data.
- R9: Outside a read data cycle (a write data cycle, after deselect, or idle), `qValid`=0 and `qOut`=0.
- R10: Address bits at and above `STORE_AW` (default 11) do not take part in decoding, so two addresses that agree in their low `STORE_AW` bits select the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of pipeline state |
| cenN | input | 1 | Clock enable, active low; high freezes the pipeline |
| csN | input | 1 | Chip select, active low; high launches no new operation |
| weN | input | 1 | Write enable, active low; captured with the address |
| oeN | input | 1 | Asynchronous output enable, active low |
| addr | input | 17 | Byte address, captured in the command cycle |
| dIn | input | 8 | Write byte, sampled at the edge that ends the write data cycle |
| qOut | output | 8 | Read byte; 0 when idle |
| qValid | output | 1 | High while a read data cycle drives `qOut` |

## Verification
A wrong captured address or write flag appears as a wrong byte or wrong `qValid` in the very next data cycle. A commit buffer that loses or misplaces its entry only shows up when a later read reaches that address. For that reason the vectors read back every written location, both right away (through the bypass) and after the buffer has drained. A pipeline that advances while clock enable is high changes `qOut` within the suspended cycle. A deselect that drops the pending write is exposed by a read two cycles later.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  // Strobes sent from the control pipeline to the datapath each cycle.
  typedef struct packed {
    logic advance;    // enabled edge: pipeline registers may move
    logic captureWr;  // write data cycle ends at this edge: take dIn into buffer
    logic commitWb;   // buffered write moves into the array at this edge
    logic wbLive;     // commit buffer holds a byte not yet in the array
    logic readLive;   // current cycle is a read data cycle
  } zbtStrobes_t;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cenN,
  input  logic        csN,
  input  logic        weN,
  output zbtStrobes_t strobes
);
  logic opValid;  // an operation was launched at the last enabled edge
  logic opWe;     // that operation is a write
  logic wbValid;  // commit buffer occupied

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid <= 1'b0;
      opWe    <= 1'b0;
      wbValid <= 1'b0;
    end else if (!cenN) begin
      opValid <= ~csN;
      opWe    <= ~weN;
      wbValid <= opValid & opWe;
    end
  end

  always_comb begin
    strobes.advance   = ~cenN;
    strobes.captureWr = ~cenN & opValid & opWe;
    strobes.commitWb  = ~cenN & wbValid;
    strobes.wbLive    = wbValid;
    strobes.readLive  = opValid & ~opWe;
  end

  // R6: a suspended edge moves no pipeline state
  p_hold_on_suspend_r6: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> ($stable(opValid) && $stable(opWe) && $stable(wbValid)));

  // R7: deselect launches no operation
  p_deselect_no_launch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && csN) |=> !opValid);

  // R3: a write data cycle that ends on an enabled edge leaves the buffer full
  p_write_buffers_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && opValid && opWe) |=> wbValid);
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  zbtStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [ADDR_W-1:0]   addrReg;
  logic [STORE_AW-1:0] rdIdx;
  logic [STORE_AW-1:0] wbAddr;
  logic [DATA_W-1:0]   wbData;
  logic [DATA_W-1:0]   store [DEPTH];
  logic                bypassHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else begin
      if (strobes.advance) addrReg <= addr;
      if (strobes.captureWr) begin
        wbAddr <= addrReg[STORE_AW-1:0];
        wbData <= dIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commitWb) store[wbAddr] <= wbData;
  end

  assign rdIdx     = addrReg[STORE_AW-1:0];
  assign bypassHit = strobes.wbLive && (wbAddr == rdIdx);
  assign rdData    = bypassHit ? wbData : store[rdIdx];

  // Upper address bits alias onto the decoded range.
  generate
    if (STORE_AW < ADDR_W) begin : g_alias
      logic unusedHigh;
      assign unusedHigh = ^addrReg[ADDR_W-1:STORE_AW];
    end
  endgenerate

  // R6: the captured address holds across a suspended edge
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(addrReg));
endmodule

// File: rtl/zbt_flow_sram.sv
module zbt_flow_sram
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int STORE_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qOut,
  output logic              qValid
);
  zbtStrobes_t       strobes;
  logic [DATA_W-1:0] rdData;

  zbt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cenN(cenN), .csN(csN), .weN(weN),
    .strobes(strobes)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_AW(STORE_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .dIn(dIn),
    .rdData(rdData)
  );

  assign qValid = strobes.readLive & ~oeN;
  assign qOut   = qValid ? rdData : '0;

  // R8: output enable deasserted means an idle port
  p_oe_forces_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!qValid && qOut == '0));

  // R2: a launched read drives valid data in its data cycle unless masked
  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && !csN && weN) |=> (oeN || qValid));

  // R9: a launched write is never a read data cycle
  p_write_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && !csN && !weN) |=> !qValid);
endmodule

// File: tb/test_zbt_flow_sram.sv
module test_zbt_flow_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cenN = 1'b1, csN = 1'b1, weN = 1'b1, oeN = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  dIn = '0;
  logic [7:0]  qOut;
  logic        qValid;
  int          checks = 0, failures = 0;

  always #5 clk = ~clk;

  zbt_flow_sram i_zbt_flow_sram (
    .clk(clk), .rstN(rstN), .cenN(cenN), .csN(csN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .qOut(qOut), .qValid(qValid)
  );

  typedef struct packed {
    logic        cenN;
    logic        csN;
    logic        weN;
    logic [16:0] addr;
    logic [7:0]  dIn;
    logic        expV;
    logic [7:0]  expQ;
    logic [3:0]  req;
  } vec_t;

  // Each row: command of this edge, dIn for the write launched on the row before,
  // and the port state expected right after this edge.
  localparam vec_t VECS [18] = '{
    '{1'b0,1'b0,1'b0,17'h00010,8'h00,1'b0,8'h00,4'd9},  // write 0x10; R9 idle
    '{1'b0,1'b0,1'b0,17'h00020,8'h11,1'b0,8'h00,4'd5},  // write 0x20 back to back; R5
    '{1'b0,1'b0,1'b1,17'h00010,8'h22,1'b1,8'h11,4'd5},  // read 0x10 right after write; R5
    '{1'b0,1'b0,1'b1,17'h00020,8'h00,1'b1,8'h22,4'd3},  // read 0x20; R3
    '{1'b0,1'b0,1'b0,17'h00030,8'h00,1'b0,8'h00,4'd5},  // read->write turn; R5
    '{1'b0,1'b0,1'b1,17'h00030,8'h33,1'b1,8'h33,4'd4},  // bypass; R4
    '{1'b0,1'b0,1'b0,17'h00040,8'h00,1'b0,8'h00,4'd9},  // write; R9
    '{1'b0,1'b0,1'b1,17'h00040,8'h44,1'b1,8'h44,4'd4},  // bypass; R4
    '{1'b0,1'b1,1'b1,17'h00010,8'h00,1'b0,8'h00,4'd7},  // deselect; R7
    '{1'b0,1'b0,1'b1,17'h00010,8'h00,1'b1,8'h11,4'd2},  // flow-through read; R2
    '{1'b0,1'b0,1'b1,17'h00810,8'h00,1'b1,8'h11,4'd10}, // alias of 0x10; R10
    '{1'b0,1'b0,1'b0,17'h1FFFF,8'h00,1'b0,8'h00,4'd9},  // write top address; R9
    '{1'b0,1'b0,1'b1,17'h007FF,8'h5A,1'b1,8'h5A,4'd10}, // alias of 0x1FFFF; R10
    '{1'b0,1'b0,1'b1,17'h00030,8'h00,1'b1,8'h33,4'd3},  // drained write; R3
    '{1'b0,1'b1,1'b0,17'h00000,8'h00,1'b0,8'h00,4'd7},  // deselect, weN ignored; R7
    '{1'b0,1'b0,1'b0,17'h00050,8'h00,1'b0,8'h00,4'd9},  // write 0x50; R9
    '{1'b0,1'b1,1'b1,17'h00000,8'h55,1'b0,8'h00,4'd7},  // deselect still takes data; R7
    '{1'b0,1'b0,1'b1,17'h00050,8'h00,1'b1,8'h55,4'd7}   // pending write completed; R7
  };

  task automatic chk(input logic ev, input logic [7:0] eq, input string req);
    checks++;
    if (qValid !== ev || qOut !== eq) begin
      failures++;
      $display("FAIL %s: got valid=%0b q=%02h, expected valid=%0b q=%02h",
               req, qValid, qOut, ev, eq);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic w,
                      input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    cenN = c; csN = s; weN = w; addr = a; dIn = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    chk(1'b0, 8'h00, "R1");  // reset leaves the port idle
    step(1'b0, 1'b1, 1'b1, 17'h0, 8'h0);
    chk(1'b0, 8'h00, "R1");

    foreach (VECS[i]) begin
      step(VECS[i].cenN, VECS[i].csN, VECS[i].weN, VECS[i].addr, VECS[i].dIn);
      chk(VECS[i].expV, VECS[i].expQ, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R6: suspension freezes a read data cycle
    step(1'b0, 1'b0, 1'b1, 17'h00010, 8'h00);
    chk(1'b1, 8'h11, "R2");
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 1'b0, 17'h00020, 8'h77);
      chk(1'b1, 8'h11, "R6");
    end
    step(1'b0, 1'b1, 1'b1, 17'h0, 8'h00);
    chk(1'b0, 8'h00, "R9");

    // R6: suspension delays the sampling of write data
    step(1'b0, 1'b0, 1'b0, 17'h00060, 8'h00);
    chk(1'b0, 8'h00, "R9");
    step(1'b1, 1'b0, 1'b1, 17'h00061, 8'h99);
    chk(1'b0, 8'h00, "R6");
    step(1'b0, 1'b0, 1'b1, 17'h00060, 8'h66);
    chk(1'b1, 8'h66, "R6");
    step(1'b0, 1'b0, 1'b1, 17'h00060, 8'h00);
    chk(1'b1, 8'h66, "R3");

    // R8: asynchronous output enable
    #1 oeN = 1'b1;
    #1 chk(1'b0, 8'h00, "R8");
    oeN = 1'b0;
    #1 chk(1'b1, 8'h66, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule